// File: doc/BRIEF.md
# General-Purpose Register File with Post-Reset Zero Sweep

This block is a processor's general-purpose register file. It provides two read ports and one write port for the pipeline. The storage array has no reset of its own, so after reset its contents are unknown. To make start-up deterministic without boot code, a small sequencer starts after every reset. It writes zero into one entry per clock cycle until every register is cleared.

While the sweep runs, the block holds its ready output low, and the core's instruction fetch waits on that output. When the last entry has been written, ready rises. A one-cycle launch pulse tells the fetch unit to issue its first request at the boot address. Register 0 is hard-wired to read as zero, so it can serve as a constant zero source.

Top module: `regfile_scrubber`

## Requirements
- R1: While `rst` is high, and from every reset until the sweep ends, `fetch_ready` is 0.
- R2: After `rst` falls, `fetch_ready` stays 0 for exactly NUM_REGS rising clock edges (32 by default, one entry cleared per edge) and is 1 after the following edge.
- R3: Once `fetch_ready` is 1 after a reset, every register reads 0 on both ports, whatever the registers held before that reset.
- R4: While `fetch_ready` is 0, both read data outputs are 0 for any read address.
- R5: A pipeline write (`wr_en`=1) made while `fetch_ready` is 0 has no effect: the target register reads 0 after the sweep.
- R6: Address 0 always reads 0 on either port, and a pipeline write to address 0 is discarded.
- R7: With `fetch_ready` at 1, a write with `wr_en`=1 to a nonzero address stores `wr_data` at the rising edge, and either read port shows it from then on.
- R8: A read of the register being written in the same cycle returns the value held before that write; there is no write-to-read forwarding.
- R9: `fetch_start` is 1 for exactly the first cycle in which `fetch_ready` is 1 after a reset, and `boot_pc` carries the boot address (0x100 by default).
- R10: Asserting `rst` at any time, including during normal operation, restarts the sweep and drops `fetch_ready` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | AW (5) | Read port A register index |
| rd_data_a | output | XLEN (32) | Read port A data, combinational |
| rd_addr_b | input | AW (5) | Read port B register index |
| rd_data_b | output | XLEN (32) | Read port B data, combinational |
| wr_en | input | 1 | Pipeline write enable |
| wr_addr | input | AW (5) | Pipeline write register index |
| wr_data | input | XLEN (32) | Pipeline write data |
| fetch_ready | output | 1 | High once the sweep has finished; gates instruction fetch |
| fetch_start | output | 1 | One-cycle pulse on the first ready cycle |
| boot_pc | output | XLEN (32) | Address of the first instruction fetch |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits and a boot address of 0x100. With these values the stall can be counted edge by edge against the exact figure of 32. The index counter reaches its all-ones value, so the final-entry and wrap conditions are exercised. Every register can be filled with nonzero data through the write port and then shown to be zero after a second reset.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int unsigned DEF_REGS  = 32;
    localparam int unsigned DEF_XLEN  = 32;
    localparam logic [31:0] DEF_BOOT  = 32'h0000_0100;

    typedef enum logic [0:0] {
        PH_SWEEP = 1'b0,
        PH_RUN   = 1'b1
    } rf_phase_e;

    function automatic logic idx_is_final(input int unsigned idx, input int unsigned depth);
        return idx == depth - 1;
    endfunction

endpackage

// File: rtl/rfs_storage.sv
module rfs_storage #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    // Plain array with no reset path: contents are unknown until written.
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/rfs_sweeper.sv
module rfs_sweeper
    import rfs_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          sweeping,
    output logic [AW-1:0] sweep_idx,
    output logic          launch
);
    rf_phase_e     phase_q;
    logic [AW-1:0] idx_q;
    logic          launch_q;
    logic          at_final;

    assign at_final = idx_is_final(int'(idx_q), DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_SWEEP;
            idx_q    <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= (phase_q == PH_SWEEP) && at_final;
            if (phase_q == PH_SWEEP) begin
                idx_q <= idx_q + 1'b1;
                if (at_final) phase_q <= PH_RUN;
            end
        end
    end

    assign sweeping  = (phase_q == PH_SWEEP);
    assign sweep_idx = idx_q;
    assign launch    = launch_q;
endmodule

// File: rtl/regfile_scrubber.sv
module regfile_scrubber
    import rfs_pkg::*;
#(
    parameter int unsigned NUM_REGS  = DEF_REGS,
    parameter int unsigned XLEN      = DEF_XLEN,
    parameter logic [31:0] BOOT_ADDR = DEF_BOOT,
    localparam int unsigned AW       = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    output logic            fetch_ready,
    output logic            fetch_start,
    output logic [XLEN-1:0] boot_pc
);
    typedef struct packed {
        logic            en;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] data;
    } wr_req_t;

    logic          sweeping;
    logic [AW-1:0] sweep_idx;
    logic          launch;
    wr_req_t       port_req, array_req;
    logic [XLEN-1:0] raw_a, raw_b;

    rfs_sweeper #(.DEPTH(NUM_REGS)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .sweeping  (sweeping),
        .sweep_idx (sweep_idx),
        .launch    (launch)
    );

    always_comb begin
        port_req.en   = wr_en && (wr_addr != '0);
        port_req.addr = wr_addr;
        port_req.data = wr_data;
        if (sweeping) begin
            array_req.en   = 1'b1;
            array_req.addr = sweep_idx;
            array_req.data = '0;
        end else begin
            array_req = port_req;
        end
    end

    rfs_storage #(.DEPTH(NUM_REGS), .WIDTH(XLEN)) u_store (
        .clk     (clk),
        .we      (array_req.en),
        .waddr   (array_req.addr),
        .wdata   (array_req.data),
        .raddr_a (rd_addr_a),
        .rdata_a (raw_a),
        .raddr_b (rd_addr_b),
        .rdata_b (raw_b)
    );

    assign rd_data_a   = (sweeping || rd_addr_a == '0) ? '0 : raw_a;
    assign rd_data_b   = (sweeping || rd_addr_b == '0) ? '0 : raw_b;
    assign fetch_ready = !sweeping;
    assign fetch_start = launch;
    assign boot_pc     = XLEN'(BOOT_ADDR);
endmodule

// File: rtl/regfile_scrubber_chk.sv
module regfile_scrubber_chk #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned XLEN     = 32,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   rd_addr_a,
    input logic [XLEN-1:0] rd_data_a,
    input logic [AW-1:0]   rd_addr_b,
    input logic [XLEN-1:0] rd_data_b,
    input logic            fetch_ready,
    input logic            fetch_start
);
    logic [15:0] stall_cnt;

    always_ff @(posedge clk) begin
        if (rst)               stall_cnt <= '0;
        else if (!fetch_ready) stall_cnt <= stall_cnt + 1'b1;
    end

    assert_ready_low_in_reset_R1: assert property (@(posedge clk) rst |=> !fetch_ready);

    assert_stall_length_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_ready) |-> (stall_cnt == 16'(NUM_REGS)));

    assert_quiet_reads_R4: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |-> (rd_data_a == '0 && rd_data_b == '0));

    assert_zero_reg_a_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    assert_zero_reg_b_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    assert_launch_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_ready) |-> fetch_start);

    assert_launch_only_ready_R9: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> fetch_ready);
endmodule

bind regfile_scrubber regfile_scrubber_chk #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_addr_a   (rd_addr_a),
    .rd_data_a   (rd_data_a),
    .rd_addr_b   (rd_addr_b),
    .rd_data_b   (rd_data_b),
    .fetch_ready (fetch_ready),
    .fetch_start (fetch_start)
);

// File: tb/test_regfile_scrubber.sv
`timescale 1ns/1ps
module test_regfile_scrubber;
    localparam int NR = 32;
    localparam int XL = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [XL-1:0] rd_data_a, rd_data_b, wr_data = '0, boot_pc;
    logic          wr_en = 1'b0, fetch_ready, fetch_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Stimulus table: {index, value}. Index 0 must read back as zero.
    localparam logic [AW+XL-1:0] VEC [8] = '{
        {5'd1,  32'h1111_0001}, {5'd31, 32'hFFFF_FFFF}, {5'd0,  32'hBAD0_0000},
        {5'd16, 32'h8000_0000}, {5'd2,  32'h0000_0001}, {5'd17, 32'h5A5A_A5A5},
        {5'd30, 32'h0F0F_F0F0}, {5'd8,  32'hCAFE_F00D}
    };

    always #2.5 clk = ~clk;

    regfile_scrubber i_regfile_scrubber (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fetch_ready(fetch_ready), .fetch_start(fetch_start), .boot_pc(boot_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [XL-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_both(input logic [AW-1:0] a, input logic [AW-1:0] b);
        rd_addr_a = a; rd_addr_b = b; #0.5;
    endtask

    // Release reset and count edges until ready, pushing a write and reads meanwhile.
    task automatic release_and_sweep(output int edges);
        edges = 0;
        rst = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'hDEAD_BEEF;
        rd_addr_a = 5'd7; rd_addr_b = 5'd9;
        while (!fetch_ready && edges < 100) begin
            #0.5;
            if (rd_data_a != '0 || rd_data_b != '0)
                chk(1'b0, "R4 read during sweep", rd_data_a | rd_data_b, '0);
            tick();
            edges++;
        end
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int edges;
        logic [XL-1:0] exp;

        // Reset state
        tick(); tick();
        chk(fetch_ready == 1'b0, "R1 ready in reset", XL'(fetch_ready), 0);
        read_both(5'd4, 5'd12);
        chk(rd_data_a == '0 && rd_data_b == '0, "R4 reads in reset", rd_data_a | rd_data_b, 0);
        chk(boot_pc == 32'h100, "R9 boot address", boot_pc, 32'h100);

        // First sweep
        release_and_sweep(edges);
        chk(edges == NR, "R2 stall length", XL'(edges), XL'(NR));
        chk(fetch_start == 1'b1, "R9 launch pulse", XL'(fetch_start), 1);
        read_both(5'd7, 5'd0);
        chk(rd_data_a == '0, "R5 write during sweep ignored", rd_data_a, 0);
        tick();
        chk(fetch_start == 1'b0, "R9 launch one cycle", XL'(fetch_start), 0);

        // Table walk
        foreach (VEC[i]) write_reg(VEC[i][AW+XL-1:XL], VEC[i][XL-1:0]);
        foreach (VEC[i]) begin
            exp = (VEC[i][AW+XL-1:XL] == '0) ? '0 : VEC[i][XL-1:0];
            read_both(VEC[i][AW+XL-1:XL], VEC[i][AW+XL-1:XL]);
            chk(rd_data_a == exp, "R7 port A readback", rd_data_a, exp);
            chk(rd_data_b == exp, "R7 port B readback", rd_data_b, exp);
        end
        read_both(5'd0, 5'd0);
        chk(rd_data_a == '0 && rd_data_b == '0, "R6 zero register", rd_data_a | rd_data_b, 0);

        // Same-cycle read returns old value
        rd_addr_a = 5'd16; wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'h1234_5678; #0.5;
        chk(rd_data_a == 32'h8000_0000, "R8 old value same cycle", rd_data_a, 32'h8000_0000);
        tick(); wr_en = 1'b0; #0.5;
        chk(rd_data_a == 32'h1234_5678, "R7 new value after edge", rd_data_a, 32'h1234_5678);

        // Fill every register, then reset mid-run
        for (int r = 1; r < NR; r++) write_reg(AW'(r), 32'hA000_0000 + XL'(r) * 32'h0101);
        read_both(5'd31, 5'd1);
        chk(rd_data_a == 32'hA000_1F1F, "R7 filled r31", rd_data_a, 32'hA000_1F1F);
        rst = 1'b1; tick();
        chk(fetch_ready == 1'b0, "R10 reset drops ready", XL'(fetch_ready), 0);
        tick();
        release_and_sweep(edges);
        chk(edges == NR, "R2 second stall length", XL'(edges), XL'(NR));
        chk(fetch_start == 1'b1, "R9 second launch", XL'(fetch_start), 1);
        for (int r = 0; r < NR; r++) begin
            read_both(AW'(r), AW'(NR - 1 - r));
            chk(rd_data_a == '0 && rd_data_b == '0, "R3 cleared after reset", rd_data_a | rd_data_b, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule